// File: doc/BRIEF.md
# Parallel Output Valid Flag Generator

This block sits at the end of a sample pipeline. It places in-phase (I) and quadrature (Q) words on a parallel word bus, one word per accepted strobe, and drives two flag lines next to the bus. The upstream datapath gives a valid strobe, a tag that marks the word as I or Q, and the word itself. The block pairs each Q with the I that came before it. It counts complete pairs to find where each output block starts and ends.

A 2-bit mode input selects how the flags are encoded. When mode bit 1 is clear, `out_sfs` marks I words and `out_rdy` marks Q words, each for one clock. When mode bit 1 is set, `out_sfs` marks every valid word and `out_rdy` becomes a level that shows a block boundary. That level is high while the first I word of a block is on the bus. A synchronous clear restarts the block counting and the pairing. A Q word that has no I before it is discarded and raises a sticky error flag.

Top module: `par_out_flags`

## Requirements
- R1: When mode[1]=0, a word accepted with `in_is_q`=0 appears on `out_word` in the next cycle. In that same cycle `out_sfs` is 1 and `out_rdy` is 0, for exactly one cycle.
- R2: When mode[1]=0, an accepted Q word appears on `out_word` in the next cycle. In that cycle `out_rdy` is 1 and `out_sfs` is 0, for exactly one cycle.
- R3: When mode[1]=1, `out_sfs` is 1 for exactly the one cycle after each accepted word, whether it is I or Q.
- R4: When mode[1]=1, `out_rdy` is a level. It becomes 1 at the edge that loads the Q word ending a block. It becomes 0 at the edge that loads any Q word that does not end a block. Loading an I word leaves it unchanged, so it is 1 while the first I word of every block is on the bus.
- R5: A block holds `blk_size` complete I/Q pairs. A `blk_size` of 0 counts as 1. A change of `blk_size` takes effect at the next pair.
- R6: After reset or a clear, no I is pending, the pair count is 0, `out_err` is 0, and the block level is 1. The first I word that follows therefore starts a block.
- R7: In a cycle with no accepted word, `out_word` keeps its value and `out_sfs` is 0. When mode[1]=0, `out_rdy` is also 0 in that cycle.
- R8: A Q word that arrives with no pending I is dropped. It does not change `out_word`, produces no flag, and does not change the count. It sets `out_err`, which stays 1 until the next clear.
- R9: An I word that arrives while an I is already pending replaces it. It is output as an I word and does not set `out_err`.
- R10: `clr` takes priority over `in_vld`. A word presented in a cycle with `clr`=1 is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the pairing, the count and the error |
| in_vld | input | 1 | Word valid strobe |
| in_is_q | input | 1 | 1 = Q word, 0 = I word |
| in_word | input | WORD_W | Sample word |
| mode | input | 2 | Flag mode; bit 1 selects the block-level encoding |
| blk_size | input | CNT_W | Complex pairs per block (0 counts as 1) |
| out_word | output | WORD_W | Parallel output word bus |
| out_sfs | output | 1 | Word flag |
| out_rdy | output | 1 | Q pulse (mode[1]=0) or block-start level (mode[1]=1) |
| out_err | output | 1 | Sticky flag for a dropped Q word |

## Verification
The bench runs every mode with block sizes 0 through 4. It mixes back-to-back pairs, idle gaps inside a pair, orphan Q words, repeated I words and clears that arrive together with a valid word. Several kinds of bug would show up. An off-by-one in the pair counter would raise the block level one pair early or late. Treating size 0 as a real zero would never end a block. A design that lowered the level on an I word would miss the first I of each block. Accepting orphan Q words, or letting a clear lose to a valid strobe, would change the bus and the flags in cycles where they must hold.

// File: rtl/pof_pkg.sv
package pof_pkg;

    typedef struct packed {
        logic pend;
        logic err;
    } pair_st_t;

    typedef struct packed {
        logic take_i;
        logic take_q;
    } pulse_st_t;

endpackage

// File: rtl/pof_pair_track.sv
module pof_pair_track
    import pof_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_vld,
    input  logic in_is_q,
    output logic take_i,
    output logic take_q,
    output logic pend,
    output logic err
);

    pair_st_t st_d, st_q;
    logic     orphan;

    always_comb begin
        take_i = in_vld && !in_is_q && !clr;
        take_q = in_vld && in_is_q && st_q.pend && !clr;
        orphan = in_vld && in_is_q && !st_q.pend && !clr;
        st_d   = st_q;
        if (clr) begin
            st_d.pend = 1'b0;
            st_d.err  = 1'b0;
        end else begin
            if (take_i) st_d.pend = 1'b1;
            if (take_q) st_d.pend = 1'b0;
            if (orphan) st_d.err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign err  = st_q.err;

endmodule

// File: rtl/pof_blk_count.sv
module pof_blk_count #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             take_q,
    input  logic [CNT_W-1:0] blk_size,
    output logic [CNT_W-1:0] cnt,
    output logic             blk_lvl
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             lvl_d, lvl_q;
    logic [EXT_W-1:0] limit;
    logic [EXT_W-1:0] next_cnt;
    logic             last;

    always_comb begin
        limit    = (blk_size == '0) ? EXT_W'(1) : {1'b0, blk_size};
        next_cnt = {1'b0, cnt_q} + EXT_W'(1);
        last     = (next_cnt >= limit);
        cnt_d    = cnt_q;
        lvl_d    = lvl_q;
        if (clr) begin
            cnt_d = '0;
            lvl_d = 1'b1;
        end else if (take_q) begin
            cnt_d = last ? '0 : next_cnt[CNT_W-1:0];
            lvl_d = last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else begin
            cnt_q <= cnt_d;
            lvl_q <= lvl_d;
        end
    end

    assign cnt     = cnt_q;
    assign blk_lvl = lvl_q;

endmodule

// File: rtl/par_out_flags.sv
module par_out_flags
    import pof_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_vld,
    input  logic              in_is_q,
    input  logic [WORD_W-1:0] in_word,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  blk_size,
    output logic [WORD_W-1:0] out_word,
    output logic              out_sfs,
    output logic              out_rdy,
    output logic              out_err
);

    logic             take_i, take_q, pend, blk_lvl;
    logic [CNT_W-1:0] cnt;

    pulse_st_t         pl_d, pl_q;
    logic [WORD_W-1:0] word_d, word_q;

    pof_pair_track i_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .in_vld  (in_vld),
        .in_is_q (in_is_q),
        .take_i  (take_i),
        .take_q  (take_q),
        .pend    (pend),
        .err     (out_err)
    );

    pof_blk_count #(.CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .take_q   (take_q),
        .blk_size (blk_size),
        .cnt      (cnt),
        .blk_lvl  (blk_lvl)
    );

    always_comb begin
        pl_d.take_i = take_i;
        pl_d.take_q = take_q;
        word_d      = (take_i || take_q) ? in_word : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q   <= '0;
            word_q <= '0;
        end else begin
            pl_q   <= pl_d;
            word_q <= word_d;
        end
    end

    assign out_word = word_q;
    assign out_sfs  = mode[1] ? (pl_q.take_i || pl_q.take_q) : pl_q.take_i;
    assign out_rdy  = mode[1] ? blk_lvl : pl_q.take_q;

endmodule

// File: rtl/pof_checker.sv
module pof_checker #(
    parameter int WORD_W = 16,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              in_vld,
    input logic              in_is_q,
    input logic [1:0]        mode,
    input logic [CNT_W-1:0]  blk_size,
    input logic [WORD_W-1:0] out_word,
    input logic              out_sfs,
    input logic              out_rdy,
    input logic              out_err,
    input logic              pend,
    input logic [CNT_W-1:0]  cnt
);

    AST_I_GIVES_SFS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_vld && !in_is_q) |=> out_sfs); // R1

    AST_MODE0_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mode[1] |-> !(out_sfs && out_rdy)); // R2

    AST_Q_GIVES_SFS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_vld && in_is_q && pend && $stable(mode) && mode[1]) |=> out_sfs); // R3

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(blk_size) && blk_size > 1) |-> (cnt < blk_size)); // R5

    AST_CLR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!out_err && !pend && cnt == '0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !in_vld) |=> ($stable(out_word) && !out_sfs)); // R7

    AST_ORPHAN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && in_vld && in_is_q && !pend) |=> (out_err && $stable(out_word) && !out_sfs)); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_err && !clr) |=> out_err); // R8

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ($stable(out_word) && !out_sfs)); // R10

endmodule

bind par_out_flags pof_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_pof_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .in_vld   (in_vld),
    .in_is_q  (in_is_q),
    .mode     (mode),
    .blk_size (blk_size),
    .out_word (out_word),
    .out_sfs  (out_sfs),
    .out_rdy  (out_rdy),
    .out_err  (out_err),
    .pend     (pend),
    .cnt      (cnt)
);

// File: tb/test_par_out_flags.sv
module test_par_out_flags;

    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 16;
    localparam int CNT_W      = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clr = 1'b0;
    logic              in_vld = 1'b0;
    logic              in_is_q = 1'b0;
    logic [WORD_W-1:0] in_word = '0;
    logic [1:0]        mode = 2'd0;
    logic [CNT_W-1:0]  blk_size = '0;
    logic [WORD_W-1:0] out_word;
    logic              out_sfs, out_rdy, out_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench-side expectations
    bit              m_pend = 1'b0;
    bit              m_lvl  = 1'b1;
    bit              m_err  = 1'b0;
    bit              m_pi   = 1'b0;
    bit              m_pq   = 1'b0;
    int              m_cnt  = 0;
    logic [WORD_W-1:0] m_word = '0;
    logic [WORD_W-1:0] seq = 16'h0100;

    par_out_flags #(.WORD_W(WORD_W), .CNT_W(CNT_W)) i_par_out_flags (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .in_is_q(in_is_q),
        .in_word(in_word), .mode(mode), .blk_size(blk_size), .out_word(out_word),
        .out_sfs(out_sfs), .out_rdy(out_rdy), .out_err(out_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (mode=%0d size=%0d t=%0t)",
                     tag, act, exp, mode, blk_size, $time);
        end
    endtask

    // one clock: drive at negedge, update expectations at posedge, compare at next negedge
    task automatic step(input bit v, input bit q, input bit c);
        int lim;
        bit orphan, blk_end;
        string t_word, t_sfs, t_rdy;
        seq     = seq + 16'h0011;
        in_vld  = v;
        in_is_q = q;
        in_word = seq;
        clr     = c;
        @(posedge clk);
        lim     = (blk_size == 0) ? 1 : int'(blk_size);
        orphan  = 1'b0;
        blk_end = 1'b0;
        if (c) begin
            m_pend = 0; m_cnt = 0; m_lvl = 1; m_err = 0; m_pi = 0; m_pq = 0;
        end else begin
            m_pi = v && !q;
            m_pq = v && q && m_pend;
            orphan = v && q && !m_pend;
            if (orphan) m_err = 1;
            if (m_pi) begin m_word = seq; m_pend = 1; end
            if (m_pq) begin
                m_word = seq; m_pend = 0;
                if (m_cnt + 1 >= lim) begin m_cnt = 0; m_lvl = 1; blk_end = 1; end
                else begin m_cnt++; m_lvl = 0; end
            end
        end
        @(negedge clk);
        in_vld = 1'b0;
        clr    = 1'b0;
        t_word = c ? "R10 word" : (orphan ? "R8 word" : ((m_pi || m_pq) ? "R1 word" : "R7 word"));
        t_sfs  = c ? "R10 sfs" : (orphan ? "R8 sfs" : (mode[1] ? "R3 sfs" : "R1 sfs"));
        t_rdy  = mode[1] ? (blk_end ? "R5 rdy" : "R4 rdy") : (m_pq ? "R2 rdy" : "R7 rdy");
        check(t_word, out_word, m_word);
        check(t_sfs, WORD_W'(out_sfs), WORD_W'(mode[1] ? (m_pi | m_pq) : m_pi));
        check(t_rdy, WORD_W'(out_rdy), WORD_W'(mode[1] ? m_lvl : m_pq));
        check(orphan ? "R8 err" : (c ? "R6 err" : "R9 err"), WORD_W'(out_err), WORD_W'(m_err));
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6 reset state
        check("R6 reset word", out_word, '0);
        check("R6 reset sfs", WORD_W'(out_sfs), '0);
        check("R6 reset err", WORD_W'(out_err), '0);
        mode = 2'd2;
        #1;
        check("R6 reset level", WORD_W'(out_rdy), WORD_W'(1));
        rst_n = 1'b1;
        @(negedge clk);
        for (int md = 0; md < 4; md++) begin
            for (int bs = 0; bs < 5; bs++) begin
                mode     = 2'(md);
                blk_size = CNT_W'(bs);
                step(0, 0, 1);
                for (int k = 0; k < 48; k++) begin
                    case ((k * 7 + md * 3 + bs) % 12)
                        6:  step(0, 0, 0);                               // idle, R7
                        7:  step(1, 1, 0);                               // Q, orphan if no I, R8
                        8:  begin step(1, 0, 0); step(1, 0, 0); step(1, 1, 0); end // R9
                        9:  begin step(1, 0, 0); step(0, 0, 0); step(1, 1, 0); end
                        10: step(1, 0, 1);                               // R10 clear wins
                        11: begin step(1, 0, 0); step(1, 1, 1); step(1, 1, 0); end // R10, R8
                        default: begin step(1, 0, 0); step(1, 1, 0); end
                    endcase
                end
            end
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule